// File: doc/BRIEF.md
# Abstract Command Instruction Generator

This block turns a register-access command from the debug logic into the instruction words a halted core fetches from the command-instruction window. That window sits directly below the program buffer, so the core runs the generated words and then falls through into the debugger's program-buffer code. The generated words move data between the data window and general register s0. The program buffer then performs the actual CSR access.

The order of the data move depends on the direction of the access. For a write, the generator places a load from the data window into s0 in the first slot. The core runs that load and then the program buffer writes the CSR, all in one pass.

A read needs two passes. In the first pass every slot is a no-op, so the core goes straight into the program buffer, which reads the CSR into s0. When that pass finishes, the generator places a store from s0 to the data window in the first slot and an ebreak in the last slot. The core runs a second pass through these words, and the ebreak stops it before it reaches the program buffer again.

The core signals the end of each pass with a one-cycle done pulse. The program buffer must end with its own ebreak, because the block appends no implicit one.

Top module: `abscmd_gen`

## Requirements
- R1: After reset, `busy` is 0, `err` is 0 and every slot reads as the no-op 0x00000013.
- R2: An accepted write-transfer command (`cmd_write`=1, `cmd_xfer`=1) makes `busy` 1 from the next cycle on. Slot 0 then reads as a load into s0 with base x0 and offset 0x380: 0x38002403 for `cmd_size`=2 (32-bit) or 0x38003403 for `cmd_size`=3 (64-bit). All other slots read as the no-op.
- R3: While a write transfer is in progress, one `exec_done` pulse ends the command: `busy` returns to 0 and all slots read as the no-op.
- R4: An accepted read-transfer command (`cmd_write`=0, `cmd_xfer`=1) first presents no-ops in all slots with `busy` at 1. After one `exec_done` pulse, `busy` stays 1, slot 0 reads as a store of s0 to offset 0x380 with base x0 (0x38802023 for size 2, 0x38803023 for size 3), and the last slot reads as ebreak 0x00100073.
- R5: A second `exec_done` pulse during a read ends the command: `busy` returns to 0 and all slots read as the no-op.
- R6: A command with `cmd_xfer`=0 presents no-ops in all slots and completes after a single `exec_done` pulse.
- R7: A command issued while `busy` is 1 is rejected. `err` becomes 1 (busy), and the slot contents and `busy` are unchanged.
- R8: An idle command whose `cmd_size` is not 2 or 3 is rejected. `err` becomes 2 (not supported), `busy` stays 0 and the slots remain no-ops.
- R9: An accepted command sets `err` back to 0.
- R10: An `exec_done` pulse while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_write | input | 1 | 1 = write the register, 0 = read it |
| cmd_xfer | input | 1 | 1 = move data through s0 |
| cmd_size | input | 3 | log2 of access bytes (2 or 3 accepted) |
| exec_done | input | 1 | Core finished a pass through the windows |
| rd_idx | input | $clog2(SLOTS) | Slot index within the command window |
| rd_word | output | 32 | Instruction word at `rd_idx` |
| busy | output | 1 | Command in progress |
| err | output | 2 | 0 none, 1 busy, 2 not supported |

## Verification
The bench builds the block with its default parameters: two slots and a largest access size of 64 bits. With two slots, the last slot is also the slot right after slot 0. Reading slot 1 therefore shows the no-op during a load pass and the ebreak during a store pass, so a single index tells the two slot layouts apart. Both accepted widths, sizes just below and just above the accepted range, and commands that collide with a pass in progress are all reachable with these values.

// File: rtl/abscmd_gen.sv
module abscmd_gen #(
  parameter int SLOTS = 2,
  parameter int MAX_LG = 3,
  parameter logic [11:0] DATA_OFS = 12'h380
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  input  logic                     cmd_write,
  input  logic                     cmd_xfer,
  input  logic [2:0]               cmd_size,
  input  logic                     exec_done,
  input  logic [$clog2(SLOTS)-1:0] rd_idx,
  output logic [31:0]              rd_word,
  output logic                     busy,
  output logic [1:0]               err
);
  localparam int IDXW = $clog2(SLOTS);
  localparam logic [IDXW-1:0] LAST = IDXW'(SLOTS - 1);
  localparam logic [31:0] NOP = 32'h0000_0013;
  localparam logic [31:0] EBRK = 32'h0010_0073;

  typedef enum logic [1:0] {ST_IDLE, ST_FIRST, ST_POST} st_t;
  st_t st;
  logic wr_q, xf_q;
  logic [1:0] sz_q;

  wire size_ok = (cmd_size >= 3'd2) && (int'(cmd_size) <= MAX_LG);
  wire [31:0] ld_word = {DATA_OFS, 5'd0, 1'b0, sz_q, 5'd8, 7'b0000011};
  wire [31:0] st_word = {DATA_OFS[11:5], 5'd8, 5'd0, 1'b0, sz_q, DATA_OFS[4:0], 7'b0100011};

  assign busy = (st != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      wr_q <= 1'b0;
      xf_q <= 1'b0;
      sz_q <= 2'd0;
      err  <= 2'd0;
    end else begin
      if (cmd_valid) begin
        if (busy) err <= 2'd1;
        else if (!size_ok) err <= 2'd2;
        else begin
          err  <= 2'd0;
          wr_q <= cmd_write;
          xf_q <= cmd_xfer;
          sz_q <= cmd_size[1:0];
        end
      end
      case (st)
        ST_IDLE:  if (cmd_valid && size_ok) st <= ST_FIRST;
        ST_FIRST: if (exec_done) st <= (xf_q && !wr_q) ? ST_POST : ST_IDLE;
        ST_POST:  if (exec_done) st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    rd_word = NOP;
    case (st)
      ST_FIRST: if (xf_q && wr_q && rd_idx == '0) rd_word = ld_word;
      ST_POST: begin
        if (rd_idx == '0) rd_word = st_word;
        else if (rd_idx == LAST) rd_word = EBRK;
      end
      default: rd_word = NOP;
    endcase
  end
endmodule

module abscmd_gen_chk #(parameter int MAX_LG = 3) (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic [2:0]  cmd_size,
  input logic        exec_done,
  input logic [31:0] rd_word,
  input logic        busy,
  input logic [1:0]  err
);
  wire good = (cmd_size >= 3'd2) && (int'(cmd_size) <= MAX_LG);

  // R1
  idle_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> rd_word == 32'h0000_0013);
  // R7
  busy_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cmd_valid && !exec_done |=> busy && err == 2'd1);
  // R8
  bad_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && cmd_valid && !good |=> !busy && err == 2'd2);
  // R9
  accept_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && cmd_valid && good |=> busy && err == 2'd0);
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !cmd_valid |=> !busy);
endmodule

bind abscmd_gen abscmd_gen_chk #(.MAX_LG(MAX_LG)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_size(cmd_size),
  .exec_done(exec_done), .rd_word(rd_word), .busy(busy), .err(err));

// File: tb/abscmd_gen_tb.sv
module abscmd_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_write = 1'b0, cmd_xfer = 1'b0, exec_done = 1'b0;
  logic [2:0] cmd_size = 3'd0;
  logic [0:0] rd_idx = 1'b0;
  logic [31:0] rd_word;
  logic busy;
  logic [1:0] err;
  int runs = 0, fails = 0;

  localparam logic [31:0] NOP = 32'h0000_0013, EBRK = 32'h0010_0073;

  always #10 clk = ~clk;

  abscmd_gen dut_i (.clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid),
    .cmd_write(cmd_write), .cmd_xfer(cmd_xfer), .cmd_size(cmd_size),
    .exec_done(exec_done), .rd_idx(rd_idx), .rd_word(rd_word),
    .busy(busy), .err(err));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic slot(string req, int idx, logic [31:0] exp);
    rd_idx = idx[0:0];
    #1;
    chk(req, rd_word, exp);
  endtask

  task automatic issue(logic w, logic x, logic [2:0] s);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = w; cmd_xfer = x; cmd_size = s;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic done_pulse();
    @(negedge clk);
    exec_done = 1'b1;
    @(negedge clk);
    exec_done = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 err", err, 0);
    slot("R1 slot0", 0, NOP);
    slot("R1 slot1", 1, NOP);
  endtask

  task automatic t_write(logic [2:0] s, logic [31:0] ld);
    issue(1, 1, s);
    chk("R2 busy", busy, 1);
    chk("R9 err", err, 0);
    slot("R2 slot0", 0, ld);
    slot("R2 slot1", 1, NOP);
    done_pulse();
    chk("R3 busy", busy, 0);
    slot("R3 slot0", 0, NOP);
  endtask

  task automatic t_read(logic [2:0] s, logic [31:0] sw);
    issue(0, 1, s);
    chk("R4 busy", busy, 1);
    slot("R4 pre slot0", 0, NOP);
    slot("R4 pre slot1", 1, NOP);
    done_pulse();
    chk("R4 busy post", busy, 1);
    slot("R4 post slot0", 0, sw);
    slot("R4 post slot1", 1, EBRK);
    done_pulse();
    chk("R5 busy", busy, 0);
    slot("R5 slot0", 0, NOP);
    slot("R5 slot1", 1, NOP);
  endtask

  task automatic t_noxfer();
    issue(1, 0, 3'd3);
    chk("R6 busy", busy, 1);
    slot("R6 slot0", 0, NOP);
    slot("R6 slot1", 1, NOP);
    done_pulse();
    chk("R6 done", busy, 0);
  endtask

  task automatic t_collide();
    issue(1, 1, 3'd3);
    issue(0, 1, 3'd2);
    chk("R7 err", err, 1);
    chk("R7 busy", busy, 1);
    slot("R7 slot0", 0, 32'h3800_3403);
    slot("R7 slot1", 1, NOP);
    done_pulse();
    chk("R7 end", busy, 0);
    issue(0, 0, 3'd2);
    chk("R9 cleared", err, 0);
    done_pulse();
  endtask

  task automatic t_badsize(logic [2:0] s);
    issue(1, 1, s);
    chk("R8 err", err, 2);
    chk("R8 busy", busy, 0);
    slot("R8 slot0", 0, NOP);
  endtask

  task automatic t_idle_done();
    done_pulse();
    chk("R10 busy", busy, 0);
    slot("R10 slot0", 0, NOP);
    chk("R10 err", err, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write(3'd3, 32'h3800_3403);
    t_write(3'd2, 32'h3800_2403);
    t_read(3'd3, 32'h3880_3023);
    t_read(3'd2, 32'h3880_2023);
    t_noxfer();
    t_collide();
    t_badsize(3'd1);
    t_badsize(3'd4);
    t_idle_done();
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    runs++;
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule